// File: doc/BRIEF.md
# Cascadable Preset Counter

A four-bit synchronous counter with a parallel preset, built to be chained into wider synchronous counters. Each rising clock edge clears it, loads the preset word, advances it or holds it. Two count enables must both be high for the counter to advance. Only the second enable also gates the carry output, so a chain of stages needs no extra gating. Each stage's carry drives the next stage's carry-gating enable, and the clock and the other enable are shared by all stages.

Two compile-time parameters pick the variant. `DECADE` chooses a 0..9 cycle or a 0..15 cycle. `ASYNC_CLR` chooses between a clear that acts at once and a clear that acts only on the next rising edge. Whatever the setting, the priority is clear, then load, then count, then hold.

Top module: `casc_counter`

## Requirements
- R1: With `ASYNC_CLR`=1, a low `clr_n` forces `q` to 0 at once, with no clock edge and whatever `load_n`, `en_p` and `en_t` are. `q` stays 0 while `clr_n` is low.
- R2: With `ASYNC_CLR`=0, a low `clr_n` leaves `q` unchanged until the next rising edge of `clk`, which sets `q` to 0.
- R3: When `load_n` is low and `clr_n` is high at a rising edge, `q` takes `din` on that edge, whatever the enables are.
- R4: When `clr_n` and `load_n` are high and `en_p` and `en_t` are both high at a rising edge, `q` advances by one step of its cycle.
- R5: When `clr_n` and `load_n` are high and at least one of `en_p` and `en_t` is low at a rising edge, `q` keeps its value.
- R6: The terminal count is 15 when `DECADE`=0 and 9 when `DECADE`=1. An advance from the terminal count gives 0.
- R7: `carry` is 1 exactly when `en_t` is 1 and `q` equals the terminal count. It follows `en_t` combinationally, with no clock edge.
- R8: With `DECADE`=1, a loaded value from 10 to 14 advances by one. 15 advances to 0. `carry` stays 0 for all values from 10 to 15.
- R9: In a chain, every stage shares `clk`, `clr_n`, `load_n` and `en_p`. Stage 0 takes the chain's `en_t`, and each later stage takes the previous stage's `carry` as its `en_t`. Three binary stages chained this way count as one 12-bit counter modulo 4096. Stage 0 holds the low nibble. The last stage's `carry` is 1 when the whole count is 4095 and the chain's `en_t` is 1.
- R10: Clear overrides load, and load overrides counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on its rising edge |
| clr_n | input | 1 | Active-low clear (immediate or edge-timed, per `ASYNC_CLR`) |
| load_n | input | 1 | Active-low parallel load of `din` |
| din | input | 4 | Preset data |
| en_p | input | 1 | Count enable that does not reach the carry |
| en_t | input | 1 | Count enable that also gates `carry` |
| q | output | 4 | Current count |
| carry | output | 1 | Terminal-count flag gated by `en_t` |

## Verification
The bound checker watches several rules on every clock edge for every instance: that `q` equals `din` after a load, that `q` steps through its cycle when both enables are high, that `q` holds otherwise, that `q` reads 0 when clear is released, and that `carry` is never high without `en_t` and the terminal count. Some behaviour can only be shown by bench scenarios. One is the instant a mid-cycle clear takes effect, and the contrast between the two clear styles within the same half-period. Others are the out-of-range decade states, and the 12-bit count of a three-stage chain compared against a plain integer model.

// File: rtl/casc_counter.sv
module casc_counter #(
  parameter bit DECADE    = 1'b0,
  parameter bit ASYNC_CLR = 1'b1
) (
  input  logic       clk,
  input  logic       clr_n,
  input  logic       load_n,
  input  logic [3:0] din,
  input  logic       en_p,
  input  logic       en_t,
  output logic [3:0] q,
  output logic       carry
);
  localparam logic [3:0] TERM = DECADE ? 4'd9 : 4'd15;

  logic [3:0] cnt, cnt_nxt;
  logic       at_term;

  assign at_term = (cnt == TERM);

  always_comb begin
    if (!load_n)            cnt_nxt = din;
    else if (en_p && en_t)  cnt_nxt = at_term ? 4'd0 : cnt + 4'd1;
    else                    cnt_nxt = cnt;
  end

  generate
    if (ASYNC_CLR) begin : g_aclr
      always_ff @(posedge clk or negedge clr_n)
        if (!clr_n) cnt <= 4'd0;
        else        cnt <= cnt_nxt;
    end else begin : g_sclr
      always_ff @(posedge clk)
        if (!clr_n) cnt <= 4'd0;
        else        cnt <= cnt_nxt;
    end
  endgenerate

  assign q     = cnt;
  assign carry = en_t & at_term;
endmodule

module casc_counter_chk #(
  parameter bit DECADE = 1'b0
) (
  input logic       clk,
  input logic       clr_n,
  input logic       load_n,
  input logic [3:0] din,
  input logic       en_p,
  input logic       en_t,
  input logic [3:0] q,
  input logic       carry
);
  localparam logic [3:0] TERM = DECADE ? 4'd9 : 4'd15;

  // R3
  load_take_chk: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> q == $past(din));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_p && en_t) |=> q == (($past(q) == TERM) ? 4'd0 : $past(q) + 4'd1));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(en_p && en_t)) |=> $stable(q));

  // R1
  clr_release_chk: assert property (@(posedge clk) disable iff (!clr_n)
    $rose(clr_n) |-> q == 4'd0);

  // R7
  carry_gate_chk: assert property (@(posedge clk) disable iff (!clr_n)
    carry |-> (en_t && q == TERM));
endmodule

bind casc_counter casc_counter_chk #(.DECADE(DECADE)) chk_i (
  .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
  .en_p(en_p), .en_t(en_t), .q(q), .carry(carry)
);

// File: tb/casc_counter_tb.sv
module casc_counter_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        clr_n = 1'b0, load_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
  logic [3:0]  din = 4'd0;
  logic [11:0] cdin = 12'd0;

  logic [3:0] qv [4];
  logic       cv [4];

  // variant index: bit0 = decade, bit1 = asynchronous clear
  casc_counter #(.DECADE(1'b0), .ASYNC_CLR(1'b0)) dut_i (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
    .en_p(en_p), .en_t(en_t), .q(qv[0]), .carry(cv[0]));
  casc_counter #(.DECADE(1'b1), .ASYNC_CLR(1'b0)) dut_i_1 (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
    .en_p(en_p), .en_t(en_t), .q(qv[1]), .carry(cv[1]));
  casc_counter #(.DECADE(1'b0), .ASYNC_CLR(1'b1)) dut_i_2 (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
    .en_p(en_p), .en_t(en_t), .q(qv[2]), .carry(cv[2]));
  casc_counter #(.DECADE(1'b1), .ASYNC_CLR(1'b1)) dut_i_3 (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
    .en_p(en_p), .en_t(en_t), .q(qv[3]), .carry(cv[3]));

  logic [3:0] cq [3];
  logic       cc [3];
  casc_counter #(.DECADE(1'b0), .ASYNC_CLR(1'b0)) stg0_i (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(cdin[3:0]),
    .en_p(en_p), .en_t(en_t), .q(cq[0]), .carry(cc[0]));
  casc_counter #(.DECADE(1'b0), .ASYNC_CLR(1'b0)) stg1_i (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(cdin[7:4]),
    .en_p(en_p), .en_t(cc[0]), .q(cq[1]), .carry(cc[1]));
  casc_counter #(.DECADE(1'b0), .ASYNC_CLR(1'b0)) stg2_i (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(cdin[11:8]),
    .en_p(en_p), .en_t(cc[1]), .q(cq[2]), .carry(cc[2]));

  int checks = 0, errors = 0;
  int m [4];
  int cm = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;
  string req = "R2";

  function automatic int adv(int v, bit dec);
    if (dec && v == 9) return 0;
    return (v + 1) % 16;
  endfunction

  task automatic check(string r, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (!clr_n)                m[i] = 0;
      else if (!load_n)          m[i] = int'(din);
      else if (en_p && en_t)     m[i] = adv(m[i], i[0]);
    end
    if (!clr_n)                  cm = 0;
    else if (!load_n)            cm = int'(cdin);
    else if (en_p && en_t)       cm = (cm + 1) % 4096;
  end

  always @(negedge clr_n) begin
    m[2] = 0;
    m[3] = 0;
  end

  always @(posedge clk) begin
    #3;
    if (cmp_on && !done) begin
      for (int i = 0; i < 4; i++) begin
        int term;
        term = i[0] ? 9 : 15;
        check(req, $sformatf("variant%0d q", i), int'(qv[i]), m[i]);
        check("R7", $sformatf("variant%0d carry", i), int'(cv[i]),
              (en_t && m[i] == term) ? 1 : 0);
      end
      check("R9", "chain count", int'({cq[2], cq[1], cq[0]}), cm);
      check("R9", "chain carry", int'(cc[2]), (en_t && cm == 4095) ? 1 : 0);
    end
  end

  task automatic drive(bit c, bit l, logic [3:0] d, bit p, bit t, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      clr_n = c; load_n = l; din = d; en_p = p; en_t = t;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(posedge clk);
    cmp_on = 1'b1;
    req = "R2";
    drive(1'b0, 1'b0, 4'd7, 1'b1, 1'b1, 2);        // R10: clear beats load
    req = "R3";
    cdin = 12'hFFB;
    drive(1'b1, 1'b0, 4'd5, 1'b0, 1'b0, 1);
    drive(1'b1, 1'b0, 4'd6, 1'b1, 1'b1, 1);        // R10: load beats count
    req = "R6";
    drive(1'b1, 1'b1, 4'd0, 1'b1, 1'b1, 20);       // R4 wrap
    req = "R5";
    drive(1'b1, 1'b0, 4'd15, 1'b0, 1'b0, 1);
    drive(1'b1, 1'b1, 4'd0, 1'b0, 1'b1, 4);
    drive(1'b1, 1'b1, 4'd0, 1'b1, 1'b0, 3);
    req = "R7";
    drive(1'b1, 1'b0, 4'd9, 1'b0, 1'b0, 1);
    drive(1'b1, 1'b1, 4'd0, 1'b0, 1'b1, 2);
    drive(1'b1, 1'b1, 4'd0, 1'b0, 1'b0, 2);
    req = "R8";
    for (int v = 10; v < 16; v++) begin
      drive(1'b1, 1'b0, 4'(v), 1'b1, 1'b1, 1);
      drive(1'b1, 1'b1, 4'd0, 1'b1, 1'b1, 3);
    end
    req = "R4";
    drive(1'b1, 1'b0, 4'd3, 1'b0, 1'b0, 1);
    drive(1'b1, 1'b1, 4'd0, 1'b1, 1'b1, 2);

    // R1: mid-cycle clear, immediate versus edge-timed
    @(negedge clk);
    clr_n = 1'b0; load_n = 1'b0; din = 4'd8; en_p = 1'b1; en_t = 1'b1;
    #1;
    check("R1", "async binary q mid-cycle", int'(qv[2]), 0);
    check("R1", "async decade q mid-cycle", int'(qv[3]), 0);
    check("R2", "sync binary q mid-cycle", int'(qv[0]), 5);
    check("R2", "sync decade q mid-cycle", int'(qv[1]), 5);
    req = "R1";
    drive(1'b0, 1'b1, 4'd0, 1'b1, 1'b1, 2);

    req = "R10";
    cdin = 12'hFF8;
    drive(1'b1, 1'b0, 4'd2, 1'b1, 1'b1, 1);
    drive(1'b1, 1'b1, 4'd0, 1'b1, 1'b1, 12);       // R9 chain overflow
    cdin = 12'h0F0;
    drive(1'b1, 1'b0, 4'd0, 1'b1, 1'b1, 1);
    drive(1'b1, 1'b1, 4'd0, 1'b1, 1'b1, 300);

    req = "R4";
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      clr_n  = ($urandom_range(0, 63) != 0);
      load_n = ($urandom_range(0, 9) != 0);
      din    = 4'($urandom);
      cdin   = 12'($urandom);
      en_p   = ($urandom_range(0, 3) != 0);
      en_t   = ($urandom_range(0, 3) != 0);
    end
    drive(1'b1, 1'b1, 4'd0, 1'b0, 1'b0, 2);
    @(negedge clk);
    finish_run();
  end
endmodule